// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block is an 18-bit first-in first-out buffer whose write port and read port each run on their own clock. The two clocks may be the same net, or they may run with no fixed relation to each other. Write and read pointers cross between the domains in Gray code, each through a two-stage synchronizer. The full-side flags are computed in the write domain and the empty-side flags in the read domain.

A mode input, captured only while reset is held, selects the read timing. In explicit-read mode every word, the first one included, reaches the output register only on a read-clock edge with the read enable high. The two fixed flags then mean "storage empty" and "storage full". In fall-through mode the head word is moved to the output register on its own, and the read enable retires it. The fixed flags then mean "output holds a word" and "room for another write". Half-full, almost-full and almost-empty flags complete the set. The two almost thresholds are loaded through the write port while a load input is high.

An output-enable input qualifies the data output. When it is low the output is held at zero and a drive-qualifier output goes low, standing in for a high-impedance pin.

Top module: `dual_clk_fifo`

## Requirements
- R1: After reset the storage is empty, the data output is zero, half-full and almost-full are 0 and almost-empty is 1. In explicit-read mode the read flag is 1 and the write flag is 0. In fall-through mode the read flag is 0 and the write flag is 1.
- R2: A word is stored on each write-clock edge where the write enable is high, the load input is low and the storage is not full. A write attempted while full is dropped, and that word never reaches the output.
- R3: In explicit-read mode the output register changes only on a read-clock edge with the read enable high and the storage not empty. A read while empty leaves the output unchanged.
- R4: In fall-through mode a word written into an empty buffer appears on the output, with the read flag at 1, on the third read-clock edge after its write edge, with no read enable. A read-clock edge with the read enable high replaces the output with the next word. If no word is stored, the read flag drops to 0 and the output holds its last value.
- R5: The read flag means storage empty in explicit-read mode and output word present in fall-through mode. The write flag means storage full in explicit-read mode and room to write in fall-through mode.
- R6: In explicit-read mode, with both clocks tied, the read flag for an empty buffer falls on the second clock edge after the edge that wrote the first word.
- R7: Half-full is 1 exactly when the write-side count of stored words is at least DEPTH/2 + 1. A full buffer is therefore always half-full.
- R8: Almost-full is 1 when the write-side count plus the almost-full offset is at least DEPTH. Almost-empty is 1 when the read-side level is at most the almost-empty offset. In fall-through mode the read-side level includes the word held in the output register.
- R9: While the load input is high, each write-clock edge with the write enable high stores the low log2(DEPTH)+1 bits of the write data as an offset, and no word enters the buffer. The first such edge sets the almost-empty offset and the second sets the almost-full offset. The sequence starts over with almost-empty whenever the load input is low. After reset both offsets equal DEF_OFF. Loading is done while the read side is idle.
- R10: While the output enable is low the data output reads zero and the drive qualifier is 0. The output enable has no effect on stored state.
- R11: The mode input is sampled only while reset is held. A change on it after reset has no effect.
- R12: Words leave the buffer in the order they were written, and the Gray-coded pointers change by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous reset, active low, released synchronously in each domain |
| ft_mode | input | 1 | Mode select captured at reset: 0 explicit read, 1 fall-through |
| wr_en | input | 1 | Write enable |
| ld_en | input | 1 | Offset load: write data goes to the offset registers instead of storage |
| wr_data | input | 18 | Write data word |
| rd_en | input | 1 | Read enable |
| out_en | input | 1 | Output enable for the data output |
| rd_data | output | 18 | Output register contents, zero while out_en is low |
| rd_oe | output | 1 | Drive qualifier for rd_data (1 = driven) |
| rd_flag | output | 1 | Empty (explicit read) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (explicit read) or input-ready (fall-through) |
| half_full | output | 1 | More than half of the storage is occupied |
| almost_empty | output | 1 | Read-side level at or below the almost-empty offset |
| almost_full | output | 1 | Write-side count within the almost-full offset of DEPTH |

## Verification
The bench builds the block with DEPTH = 16 and DEF_OFF = 7, and drives both clocks from one net. This makes the synchronizer latencies exact cycle counts. Sixteen words are enough to reach full, to drop writes made while full, and to cross the half-full, almost-full and almost-empty thresholds at both the default offsets and at loaded offsets of 3 and 12. In fall-through mode the small depth also pins the exact number of words accepted while the first word is still moving toward the output.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W = 18;

  typedef enum logic {
    MODE_STD = 1'b0,
    MODE_FT  = 1'b1
  } mode_e;

  typedef enum logic {
    SLOT_AE = 1'b0,
    SLOT_AF = 1'b1
  } ld_slot_e;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign rst_n = stage[1];
endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_gray,
  output logic [W-1:0] q_bin
);
  logic [W-1:0] s1, s2;

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d_gray;
      s2 <= s1;
    end
  end

  assign q_bin = gray_to_bin(s2);
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DEF_OFF = 7,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_in,
  input  logic              wr_en,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PW-1:0]     rbin_sync,
  output logic              push,
  output logic [AW-1:0]     waddr,
  output logic [PW-1:0]     wgray,
  output logic [PW-1:0]     wcnt,
  output logic              full,
  output logic              half,
  output logic              almost_full,
  output logic              wr_flag,
  output logic [PW-1:0]     ae_off,
  output mode_e             mode_q
);
  logic [PW-1:0] wbin, wbin_nxt, af_off;
  ld_slot_e      slot;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic near_top(input logic [PW-1:0] cnt, input logic [PW-1:0] off);
    return ({1'b0, cnt} + {1'b0, off}) >= (PW+1)'(DEPTH);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_e'(mode_in);
  end

  assign wcnt     = wbin - rbin_sync;
  assign full     = (wcnt == PW'(DEPTH));
  assign push     = wr_en & ~ld_en & ~full;
  assign wbin_nxt = wbin + PW'(push);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      ae_off <= PW'(DEF_OFF);
      af_off <= PW'(DEF_OFF);
      slot   <= SLOT_AE;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= to_gray(wbin_nxt);
      if (ld_en && wr_en) begin
        if (slot == SLOT_AE) ae_off <= wr_data[PW-1:0];
        else                 af_off <= wr_data[PW-1:0];
        slot <= (slot == SLOT_AE) ? SLOT_AF : SLOT_AE;
      end else if (!ld_en) begin
        slot <= SLOT_AE;
      end
    end
  end

  assign waddr       = wbin[AW-1:0];
  assign half        = (wcnt > PW'(DEPTH / 2));
  assign almost_full = near_top(wcnt, af_off);
  assign wr_flag     = (mode_q == MODE_FT) ? ~full : full;
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_in,
  input  logic              rd_en,
  input  logic [PW-1:0]     wbin_sync,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [PW-1:0]     ae_off,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     rgray,
  output logic [DATA_W-1:0] q,
  output logic              ovld,
  output logic              mem_empty,
  output logic              rd_flag,
  output logic              almost_empty,
  output mode_e             mode_q
);
  logic [PW-1:0] rbin, rbin_nxt, rcnt, level;
  logic          ft, take;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_e'(mode_in);
  end

  assign ft        = (mode_q == MODE_FT);
  assign rcnt      = wbin_sync - rbin;
  assign mem_empty = (rcnt == '0);
  assign take      = ~mem_empty & (ft ? (~ovld | rd_en) : rd_en);
  assign rbin_nxt  = rbin + PW'(take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      q     <= '0;
      ovld  <= 1'b0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= to_gray(rbin_nxt);
      if (take) q <= rd_word;
      if (take)       ovld <= ft;
      else if (rd_en) ovld <= 1'b0;
    end
  end

  assign raddr        = rbin[AW-1:0];
  assign level        = rcnt + PW'(ovld);
  assign almost_empty = (level <= ae_off);
  assign rd_flag      = ft ? ovld : mem_empty;
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DEF_OFF = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              arst_n,
  input  logic              ft_mode,
  input  logic              wr_en,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              rd_flag,
  output logic              wr_flag,
  output logic              half_full,
  output logic              almost_empty,
  output logic              almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // Named internal events, also observed by the bound checker
  logic              w_rst_n, r_rst_n;
  logic              w_push, w_full, w_half;
  logic [AW-1:0]     w_addr, r_addr;
  logic [PW-1:0]     w_gray, w_cnt, r_gray, w_rbin, r_wbin, ae_off;
  logic [DATA_W-1:0] r_word, r_q;
  logic              r_ovld, r_mem_empty;
  mode_e             w_mode, r_mode;

  logic [DATA_W-1:0] mem [DEPTH];

  dcf_rst_sync u_wrst (.clk(wr_clk), .arst_n(arst_n), .rst_n(w_rst_n));
  dcf_rst_sync u_rrst (.clk(rd_clk), .arst_n(arst_n), .rst_n(r_rst_n));

  dcf_gray_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(w_rst_n), .d_gray(r_gray), .q_bin(w_rbin));
  dcf_gray_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(r_rst_n), .d_gray(w_gray), .q_bin(r_wbin));

  dcf_wr_side #(.DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) u_wr (
    .clk(wr_clk), .rst_n(w_rst_n), .mode_in(ft_mode), .wr_en(wr_en), .ld_en(ld_en),
    .wr_data(wr_data), .rbin_sync(w_rbin), .push(w_push), .waddr(w_addr), .wgray(w_gray),
    .wcnt(w_cnt), .full(w_full), .half(w_half), .almost_full(almost_full),
    .wr_flag(wr_flag), .ae_off(ae_off), .mode_q(w_mode)
  );

  dcf_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst_n(r_rst_n), .mode_in(ft_mode), .rd_en(rd_en), .wbin_sync(r_wbin),
    .rd_word(r_word), .ae_off(ae_off), .raddr(r_addr), .rgray(r_gray), .q(r_q),
    .ovld(r_ovld), .mem_empty(r_mem_empty), .rd_flag(rd_flag),
    .almost_empty(almost_empty), .mode_q(r_mode)
  );

  always_ff @(posedge wr_clk) begin
    if (w_push) mem[w_addr] <= wr_data;
  end

  assign r_word    = mem[r_addr];
  assign half_full = w_half;
  assign rd_oe     = out_en;
  assign rd_data   = out_en ? r_q : '0;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PW    = 9
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              w_rst_n,
  input logic              r_rst_n,
  input logic              ld_en,
  input logic              rd_en,
  input logic [PW-1:0]     w_cnt,
  input logic [PW-1:0]     w_gray,
  input logic [PW-1:0]     r_gray,
  input logic              w_full,
  input logic              w_half,
  input logic [DATA_W-1:0] r_q,
  input logic              r_ovld,
  input logic              r_mem_empty,
  input mode_e             w_mode,
  input mode_e             r_mode
);
  p_cnt_bound_r2: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    w_cnt <= PW'(DEPTH));

  p_empty_read_r3: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (r_mode == MODE_STD && r_mem_empty && rd_en) |=> $stable(r_q));

  p_ft_hold_r4: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (r_mode == MODE_FT && r_ovld && !rd_en) |=> (r_ovld && $stable(r_q)));

  p_std_no_ovld_r5: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (r_mode == MODE_STD) |=> !r_ovld);

  p_full_half_r7: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    w_full |-> w_half);

  p_load_no_push_r9: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    ld_en |=> $stable(w_gray));

  p_wmode_fixed_r11: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    1'b1 |=> $stable(w_mode));

  p_rmode_fixed_r11: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    1'b1 |=> $stable(r_mode));

  p_wgray_step_r12: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    1'b1 |=> ($countones(w_gray ^ $past(w_gray)) <= 1));

  p_rgray_step_r12: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    1'b1 |=> ($countones(r_gray ^ $past(r_gray)) <= 1));
endmodule

bind dual_clk_fifo dcf_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .ld_en(ld_en), .rd_en(rd_en), .w_cnt(w_cnt), .w_gray(w_gray), .r_gray(r_gray),
  .w_full(w_full), .w_half(w_half), .r_q(r_q), .r_ovld(r_ovld),
  .r_mem_empty(r_mem_empty), .w_mode(w_mode), .r_mode(r_mode)
);

// File: tb/sim_dual_clk_fifo.sv
module sim_dual_clk_fifo;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0, ft_mode = 1'b0;
  logic        wr_en = 1'b0, ld_en = 1'b0, rd_en = 1'b0, out_en = 1'b1;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic        rd_oe, rd_flag, wr_flag, half_full, almost_empty, almost_full;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dual_clk_fifo #(.DEPTH(16), .DEF_OFF(7)) u0 (
    .wr_clk(clk), .rd_clk(clk), .arst_n(arst_n), .ft_mode(ft_mode), .wr_en(wr_en),
    .ld_en(ld_en), .wr_data(wr_data), .rd_en(rd_en), .out_en(out_en), .rd_data(rd_data),
    .rd_oe(rd_oe), .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  // {wr, rd, check_q, exp_rd_flag, din[17:0], exp_q[17:0]}
  localparam logic [39:0] VEC [11] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 18'h2A5A5, 18'h00000},
    {1'b1, 1'b0, 1'b0, 1'b1, 18'h15A5A, 18'h00000},
    {1'b1, 1'b0, 1'b0, 1'b0, 18'h3FF00, 18'h00000},
    {1'b1, 1'b0, 1'b0, 1'b0, 18'h000FF, 18'h00000},
    {1'b0, 1'b0, 1'b0, 1'b0, 18'h00000, 18'h00000},
    {1'b0, 1'b0, 1'b0, 1'b0, 18'h00000, 18'h00000},
    {1'b0, 1'b1, 1'b1, 1'b0, 18'h00000, 18'h2A5A5},
    {1'b0, 1'b1, 1'b1, 1'b0, 18'h00000, 18'h15A5A},
    {1'b0, 1'b1, 1'b1, 1'b0, 18'h00000, 18'h3FF00},
    {1'b0, 1'b1, 1'b1, 1'b1, 18'h00000, 18'h000FF},
    {1'b0, 1'b1, 1'b1, 1'b1, 18'h00000, 18'h000FF}
  };

  function automatic logic [17:0] fill_word(input int i);
    return 18'(i * 18'h1111 + 5);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic l, input logic [17:0] d);
    wr_en = w; rd_en = r; ld_en = l; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; ld_en = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    arst_n = 1'b0; ft_mode = mode;
    wr_en = 1'b0; rd_en = 1'b0; ld_en = 1'b0; out_en = 1'b1;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [17:0] last;
    int          got;
    // ---------------- explicit-read mode ----------------
    do_reset(1'b0);
    chk("R1 rd_flag", 32'(rd_flag), 1);
    chk("R1 wr_flag", 32'(wr_flag), 0);
    chk("R1 almost_empty", 32'(almost_empty), 1);
    chk("R1 almost_full", 32'(almost_full), 0);
    chk("R1 half_full", 32'(half_full), 0);
    chk("R1 rd_data", 32'(rd_data), 0);

    // table walk: R3 ordering, R6 empty latency, empty read ignored
    for (int i = 0; i < 11; i++) begin
      step(VEC[i][39], VEC[i][38], 1'b0, VEC[i][35:18]);
      chk("R6 rd_flag per vector", 32'(rd_flag), 32'(VEC[i][36]));
      if (VEC[i][37]) chk("R3 rd_data per vector", 32'(rd_data), 32'(VEC[i][17:0]));
    end

    // fill to full: R7, R8, R5, R2
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0, 1'b0, fill_word(i));
      if (i == 7) begin
        chk("R7 half_full at 8", 32'(half_full), 0);
        chk("R8 almost_full at 8", 32'(almost_full), 0);
      end
      if (i == 8) begin
        chk("R7 half_full at 9", 32'(half_full), 1);
        chk("R8 almost_full at 9", 32'(almost_full), 1);
      end
    end
    chk("R5 full flag", 32'(wr_flag), 1);
    step(1'b1, 1'b0, 1'b0, 18'h3FFFF);
    chk("R2 still full after dropped write", 32'(wr_flag), 1);
    step(1'b0, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R8 almost_empty at 16", 32'(almost_empty), 0);
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b1, 1'b0, '0);
      chk("R12 read order", 32'(rd_data), 32'(fill_word(i)));
      if (i == 7) chk("R8 almost_empty at 8", 32'(almost_empty), 0);
      if (i == 8) chk("R8 almost_empty at 7", 32'(almost_empty), 1);
    end
    step(1'b0, 1'b1, 1'b0, '0);
    chk("R2 dropped word absent", 32'(rd_data), 32'(fill_word(15)));
    chk("R3 empty after drain", 32'(rd_flag), 1);
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R5 full cleared", 32'(wr_flag), 0);

    // output enable: R10
    out_en = 1'b0;
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R10 data gated", 32'(rd_data), 0);
    chk("R10 qualifier low", 32'(rd_oe), 0);
    out_en = 1'b1;
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R10 state kept", 32'(rd_data), 32'(fill_word(15)));
    chk("R10 qualifier high", 32'(rd_oe), 1);

    // offset load: R9 (ae=3, af=12)
    step(1'b1, 1'b0, 1'b1, 18'd3);
    step(1'b1, 1'b0, 1'b1, 18'd12);
    repeat (3) step(1'b0, 1'b0, 1'b0, '0);
    chk("R9 load stores no word", 32'(rd_flag), 1);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 18'(18'h20000 + i));
    chk("R9 almost_full off at 3", 32'(almost_full), 0);
    step(1'b1, 1'b0, 1'b0, 18'h20003);
    chk("R9 almost_full on at 4", 32'(almost_full), 1);
    step(1'b0, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R9 almost_empty off at 4", 32'(almost_empty), 0);
    step(1'b0, 1'b1, 1'b0, '0);
    chk("R9 almost_empty on at 3", 32'(almost_empty), 1);
    chk("R12 first after load", 32'(rd_data), 32'h20000);

    // mode change without reset: R11
    ft_mode = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0, '0);
    chk("R11 no fall-through", 32'(rd_data), 32'h20000);
    chk("R11 flag keeps empty meaning", 32'(rd_flag), 0);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    chk("R1 ft rd_flag", 32'(rd_flag), 0);
    chk("R1 ft wr_flag", 32'(wr_flag), 1);
    step(1'b1, 1'b0, 1'b0, 18'h1BEEF);
    chk("R4 edge 0", 32'(rd_flag), 0);
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R4 edge 1", 32'(rd_flag), 0);
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R4 edge 2", 32'(rd_flag), 0);
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R4 edge 3 ready", 32'(rd_flag), 1);
    chk("R4 edge 3 data", 32'(rd_data), 32'h1BEEF);
    chk("R8 ft level counts output word", 32'(almost_empty), 1);
    step(1'b0, 1'b1, 1'b0, '0);
    chk("R4 ready drops", 32'(rd_flag), 0);
    chk("R4 data held", 32'(rd_data), 32'h1BEEF);

    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 18'(18'h10000 + i * 7));
    chk("R5 input-ready low when full", 32'(wr_flag), 0);
    repeat (2) step(1'b0, 1'b0, 1'b0, '0);
    chk("R4 head ready", 32'(rd_flag), 1);
    chk("R12 ft head", 32'(rd_data), 32'h10000);
    got = 1;
    last = rd_data;
    for (int i = 1; i < 20; i++) begin
      step(1'b0, 1'b1, 1'b0, '0);
      if (rd_flag) begin
        got++;
        chk("R12 ft order", 32'(rd_data), 32'(18'h10000 + i * 7));
        last = rd_data;
      end
    end
    chk("R2 ft accepted count", 32'(got), 17);
    chk("R4 last data held", 32'(rd_data), 32'(last));
    repeat (2) step(1'b0, 1'b0, 1'b0, '0);
    chk("R5 input-ready back", 32'(wr_flag), 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule